// File: doc/BRIEF.md
# Timestamped Event Lane Distributor

This block accepts a stream of timestamped output events (a coarse timestamp, a fine timestamp, a channel number and a data word) over a valid/ready handshake. It writes each event into one of several parallel lane FIFOs, chosen so that every lane receives coarse timestamps in strictly increasing order. A current-lane pointer moves to the next lane, wrapping at the lane count, whenever the incoming timestamp does not exceed the last one written to the current lane. If the next lane cannot take the event either, the event is dropped and a sequence-error pulse is raised.

A configuration input turns on spreading. With spreading on, the pointer also moves on as soon as the current lane's fill level reaches a high watermark. More events can then be buffered before the input has to wait. When the target lane is full, the handshake simply holds the event back; no overflow is ever reported. The free space left in the fullest lane is reported as a credit for upstream flow control.

Each lane is emptied by a simple real-time model. A free-running coarse time counter pops a lane's head event once the counter has reached that event's coarse timestamp.

Top module: `lane_spreader`

## Requirements
- R1: With spread_en low, the pointer moves only for timestamp-order reasons. A stream of strictly increasing coarse timestamps is written to a single lane, and when that lane holds DEPTH events the input stalls, even though the other lanes are empty.
- R2: An event whose coarse timestamp is less than or equal to the last one written to the current lane is steered to lane (current+1) mod NUM_LANES. Events that share a coarse value therefore each take a different lane, whatever their fine timestamps. At most one bit of lane_wr_en is set in any cycle.
- R3: If the lane reached by a hop already holds a last coarse timestamp greater than or equal to the event's, the event is accepted (ev_ready high) but not written. seq_err is high for exactly the one cycle after the acceptance, and the pointer still moves to that lane. More than NUM_LANES events at one coarse value therefore produce a sequence error.
- R4: With spreading off, the lane choice and the error outcome of a timestamp sequence depend only on the sequence, starting from reset. Adding a constant to every timestamp leaves them unchanged.
- R5: With spread_en high, an event also hops to the next lane when the current lane's occupancy is at least HIGH_MARK. The same last-timestamp check and drop rule as in R3 applies to such a hop.
- R6: When the target lane is full and the event is not a sequence error, ev_ready is low, stall is high and nothing is written. The event is held and is written in the first cycle in which its lane has space.
- R7: min_free equals DEPTH minus the largest lane occupancy.
- R8: After reset the pointer is at lane 0, every lane's last timestamp is 0, all lanes are empty, now_coarse is 0, seq_err is low and min_free equals DEPTH. As a result, an event with coarse timestamp 0 right after reset is a sequence error.
- R9: now_coarse counts up by one every clock after reset. drain_pop[i] is high in a cycle where lane i is not empty and now_coarse is greater than or equal to the coarse timestamp of its head event, and the head leaves the lane at that edge.
- R10: An event is packed as {coarse, fine, chan, data}, with coarse in the most significant bits. It appears in this form on lane_wr_ev, and the head of lane i appears on drain_ev[i*EV_W +: EV_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spread_en | input | 1 | Enables watermark-triggered lane hops |
| ev_valid | input | 1 | Input event present |
| ev_ready | output | 1 | Input event taken this cycle (written or dropped) |
| ev_coarse | input | CT_W | Coarse timestamp |
| ev_fine | input | FT_W | Fine timestamp |
| ev_chan | input | CH_W | Channel number |
| ev_data | input | DATA_W | Event payload |
| lane_wr_en | output | NUM_LANES | One-hot write strobe into the lanes |
| lane_wr_ev | output | EV_W | Packed event being written |
| seq_err | output | 1 | One-cycle pulse after a dropped event |
| stall | output | 1 | Event present but held back |
| min_free | output | CNT_W | Free entries in the fullest lane |
| now_coarse | output | CT_W | Free-running coarse time counter |
| drain_pop | output | NUM_LANES | Per-lane pop strobe of the drain model |
| drain_ev | output | NUM_LANES*EV_W | Head event of every lane |

## Verification
The hardest condition to reach is a watermark-triggered hop that lands on a lane whose last timestamp is too high. To get there, the pointer has to sit on a lane filled to the watermark, and the lane after it must have received a later timestamp earlier in the run. The bench builds this state with spreading off: descending timestamps walk the pointer across all lanes, and increasing events then fill the last lane. Only after that does it raise spread_en and offer the next event. A full-lane stall is reached by placing timestamps far ahead of the time counter. The bench then waits until the counter reaches the head timestamp, so that it can observe the exact cycle of the release.

// File: rtl/lane_spread_pkg.sv
package lane_spread_pkg;

    // Why the lane pointer moves for the event being offered
    typedef enum logic [1:0] {
        HOP_NONE  = 2'd0,
        HOP_ORDER = 2'd1,
        HOP_MARK  = 2'd2
    } hop_cause_e;

endpackage

// File: rtl/lsd_lane_fifo.sv
module lsd_lane_fifo #(
    parameter int W     = 59,
    parameter int DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [W-1:0]                   push_data,
    input  logic                           pop,
    output logic [W-1:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        if (pop)  st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        case ({push, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wr_ptr] <= push_data;
    end

    assign head  = mem[st_q.rd_ptr];
    assign count = st_q.count;

endmodule

// File: rtl/lsd_lane_pick.sv
module lsd_lane_pick
    import lane_spread_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int CT_W      = 32,
    parameter int DEPTH     = 8,
    parameter int HIGH_MARK = 6,
    localparam int LANE_W   = $clog2(NUM_LANES),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                                cur_lane,
    input  logic [LANE_W-1:0]                   cur_idx,
    input  logic [NUM_LANES-1:0][CT_W-1:0]      last_ts,
    input  logic [NUM_LANES-1:0][CNT_W-1:0]     occ,
    input  logic [CT_W-1:0]                     ev_coarse,
    input  logic                                spread_en,
    output logic [LANE_W-1:0]                   tgt_lane,
    output hop_cause_e                          cause,
    output logic                                order_err,
    output logic                                tgt_full
);
    logic [LANE_W-1:0] nxt_lane;
    logic              order_hit;
    logic              mark_hit;

    always_comb begin
        nxt_lane  = (cur_idx == LANE_W'(NUM_LANES - 1)) ? '0 : cur_idx + 1'b1;
        order_hit = (ev_coarse <= last_ts[cur_idx]);
        mark_hit  = spread_en && cur_lane && (occ[cur_idx] >= CNT_W'(HIGH_MARK));

        if (order_hit)     cause = HOP_ORDER;
        else if (mark_hit) cause = HOP_MARK;
        else               cause = HOP_NONE;

        tgt_lane  = (cause == HOP_NONE) ? cur_idx : nxt_lane;
        order_err = (cause != HOP_NONE) && (last_ts[nxt_lane] >= ev_coarse);
        tgt_full  = (occ[tgt_lane] == CNT_W'(DEPTH));
    end

endmodule

// File: rtl/lsd_fill_gauge.sv
module lsd_fill_gauge #(
    parameter int NUM_LANES = 4,
    parameter int DEPTH     = 8,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic [NUM_LANES-1:0][CNT_W-1:0] occ,
    output logic [CNT_W-1:0]                min_free
);
    logic [CNT_W-1:0] peak;

    always_comb begin
        peak = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (occ[i] > peak) peak = occ[i];
        end
        min_free = CNT_W'(DEPTH) - peak;
    end

endmodule

// File: rtl/lane_spreader.sv
module lane_spreader
    import lane_spread_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int DEPTH     = 8,
    parameter int HIGH_MARK = 6,
    parameter int CT_W      = 32,
    parameter int FT_W      = 3,
    parameter int CH_W      = 8,
    parameter int DATA_W    = 16,
    localparam int LANE_W   = $clog2(NUM_LANES),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int EV_W     = CT_W + FT_W + CH_W + DATA_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        spread_en,
    input  logic                        ev_valid,
    output logic                        ev_ready,
    input  logic [CT_W-1:0]             ev_coarse,
    input  logic [FT_W-1:0]             ev_fine,
    input  logic [CH_W-1:0]             ev_chan,
    input  logic [DATA_W-1:0]           ev_data,
    output logic [NUM_LANES-1:0]        lane_wr_en,
    output logic [EV_W-1:0]             lane_wr_ev,
    output logic                        seq_err,
    output logic                        stall,
    output logic [CNT_W-1:0]            min_free,
    output logic [CT_W-1:0]             now_coarse,
    output logic [NUM_LANES-1:0]        drain_pop,
    output logic [NUM_LANES*EV_W-1:0]   drain_ev
);
    typedef struct packed {
        logic [LANE_W-1:0]                 cur_lane;
        logic [NUM_LANES-1:0][CT_W-1:0]    last_ts;
        logic [CT_W-1:0]                   now;
        logic                              seq_err;
    } dist_state_t;

    dist_state_t st_d, st_q;

    logic [NUM_LANES-1:0][CNT_W-1:0] occ;
    logic [NUM_LANES-1:0][EV_W-1:0]  head;
    logic [LANE_W-1:0]               tgt_lane;
    hop_cause_e                      cause;
    logic                            order_err;
    logic                            tgt_full;
    logic                            accept;
    logic                            do_write;
    logic [EV_W-1:0]                 ev_packed;

    assign ev_packed = {ev_coarse, ev_fine, ev_chan, ev_data};

    lsd_lane_pick #(
        .NUM_LANES (NUM_LANES),
        .CT_W      (CT_W),
        .DEPTH     (DEPTH),
        .HIGH_MARK (HIGH_MARK)
    ) pick_i (
        .cur_lane  (1'b1),
        .cur_idx   (st_q.cur_lane),
        .last_ts   (st_q.last_ts),
        .occ       (occ),
        .ev_coarse (ev_coarse),
        .spread_en (spread_en),
        .tgt_lane  (tgt_lane),
        .cause     (cause),
        .order_err (order_err),
        .tgt_full  (tgt_full)
    );

    lsd_fill_gauge #(
        .NUM_LANES (NUM_LANES),
        .DEPTH     (DEPTH)
    ) gauge_i (
        .occ      (occ),
        .min_free (min_free)
    );

    // Handshake and steering
    always_comb begin
        ev_ready = order_err || !tgt_full;
        accept   = ev_valid && ev_ready;
        do_write = accept && !order_err;
        stall    = ev_valid && !ev_ready;
        for (int i = 0; i < NUM_LANES; i++) begin
            lane_wr_en[i] = do_write && (tgt_lane == LANE_W'(i));
        end
    end

    // Next-state computation
    always_comb begin
        st_d         = st_q;
        st_d.now     = st_q.now + 1'b1;
        st_d.seq_err = accept && order_err;
        if (accept && (cause != HOP_NONE)) st_d.cur_lane = tgt_lane;
        if (do_write) st_d.last_ts[tgt_lane] = ev_coarse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Lanes and their real-time drain model
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic pop_g;
        assign pop_g = (occ[g] != '0) && (st_q.now >= head[g][EV_W-1 -: CT_W]);
        assign drain_pop[g] = pop_g;
        assign drain_ev[g*EV_W +: EV_W] = head[g];

        lsd_lane_fifo #(
            .W     (EV_W),
            .DEPTH (DEPTH)
        ) fifo_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (lane_wr_en[g]),
            .push_data (ev_packed),
            .pop       (pop_g),
            .head      (head[g]),
            .count     (occ[g])
        );
    end

    assign lane_wr_ev = ev_packed;
    assign seq_err    = st_q.seq_err;
    assign now_coarse = st_q.now;

endmodule

module lane_spreader_chk #(
    parameter int NUM_LANES = 4,
    parameter int CNT_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ev_valid,
    input logic                 ev_ready,
    input logic [NUM_LANES-1:0] lane_wr_en,
    input logic                 seq_err,
    input logic                 stall,
    input logic [CNT_W-1:0]     min_free,
    input logic [NUM_LANES-1:0] drain_pop
);
    // R2
    wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_wr_en));

    // R6
    stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (lane_wr_en == '0));

    // R6
    write_needs_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr_en != '0) |-> (ev_valid && ev_ready));

    // R3
    seq_err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> $past(ev_valid && ev_ready && (lane_wr_en == '0)));

    // R7
    credit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_wr_en == '0) && (drain_pop == '0)) |=> $stable(min_free));
endmodule

bind lane_spreader lane_spreader_chk #(
    .NUM_LANES (NUM_LANES),
    .CNT_W     (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .lane_wr_en (lane_wr_en),
    .seq_err    (seq_err),
    .stall      (stall),
    .min_free   (min_free),
    .drain_pop  (drain_pop)
);

// File: tb/lane_spreader_tb_top.sv
module lane_spreader_tb_top;
    localparam int NL    = 4;
    localparam int DEP   = 8;
    localparam int MARK  = 6;
    localparam int CT_W  = 32;
    localparam int FT_W  = 3;
    localparam int CH_W  = 8;
    localparam int DW    = 16;
    localparam int EV_W  = CT_W + FT_W + CH_W + DW;
    localparam int CNT_W = $clog2(DEP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spread_en = 1'b0;
    logic ev_valid = 1'b0;
    logic ev_ready;
    logic [CT_W-1:0] ev_coarse = '0;
    logic [FT_W-1:0] ev_fine = '0;
    logic [CH_W-1:0] ev_chan = '0;
    logic [DW-1:0]   ev_data = '0;
    logic [NL-1:0]   lane_wr_en;
    logic [EV_W-1:0] lane_wr_ev;
    logic            seq_err;
    logic            stall;
    logic [CNT_W-1:0] min_free;
    logic [CT_W-1:0] now_coarse;
    logic [NL-1:0]   drain_pop;
    logic [NL*EV_W-1:0] drain_ev;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lane_spreader #(
        .NUM_LANES (NL), .DEPTH (DEP), .HIGH_MARK (MARK),
        .CT_W (CT_W), .FT_W (FT_W), .CH_W (CH_W), .DATA_W (DW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .spread_en (spread_en),
        .ev_valid (ev_valid), .ev_ready (ev_ready),
        .ev_coarse (ev_coarse), .ev_fine (ev_fine), .ev_chan (ev_chan), .ev_data (ev_data),
        .lane_wr_en (lane_wr_en), .lane_wr_ev (lane_wr_ev), .seq_err (seq_err),
        .stall (stall), .min_free (min_free), .now_coarse (now_coarse),
        .drain_pop (drain_pop), .drain_ev (drain_ev)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ev_valid = 1'b0; spread_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [NL-1:0] lane_bit(input int lane);
        return (lane < 0) ? '0 : NL'(1) << lane;
    endfunction

    // Offer one event that is expected to be taken at once; lane -1 = dropped
    task automatic send(input string tag, input int unsigned ts, input int fine, input int lane);
        logic [EV_W-1:0] exp_ev;
        @(negedge clk);
        ev_valid = 1'b1; ev_coarse = ts; ev_fine = FT_W'(fine);
        ev_chan = CH_W'(ts * 3); ev_data = DW'(ts ^ 16'h5a5a);
        exp_ev = {ev_coarse, ev_fine, ev_chan, ev_data};
        #1;
        chk({tag, " ready"}, 64'(ev_ready), 64'd1);
        chk({tag, " lane"}, 64'(lane_wr_en), 64'(lane_bit(lane)));
        if (lane >= 0) chk({tag, " R10 payload"}, 64'(lane_wr_ev[EV_W-1 -: 40]), 64'(exp_ev[EV_W-1 -: 40]));
        @(negedge clk);
        ev_valid = 1'b0;
        chk({tag, " R3 seq_err"}, 64'(seq_err), 64'(lane < 0));
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        chk("R8 now zero", 64'(now_coarse), 64'd0);
        chk("R8 credit", 64'(min_free), 64'(DEP));
        chk("R8 seq_err", 64'(seq_err), 64'd0);
        chk("R8 no pop", 64'(drain_pop), 64'd0);
        @(negedge clk); #1;
        chk("R9 now counts", 64'(now_coarse), 64'd1);
        send("R8 zero ts error", 0, 0, -1);
    endtask

    task automatic t_single_lane_stall();
        do_reset();
        for (int k = 0; k < DEP; k++) send("R1 increasing", 1000 + k, 0, 0);
        #1;
        chk("R7 credit full lane", 64'(min_free), 64'd0);
        @(negedge clk);
        ev_valid = 1'b1; ev_coarse = 1008; ev_fine = '0; ev_chan = '0; ev_data = 16'h1234;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R1 stall", 64'(stall), 64'd1);
            chk("R6 ready low", 64'(ev_ready), 64'd0);
            chk("R6 no write", 64'(lane_wr_en), 64'd0);
            @(negedge clk);
        end
        while (now_coarse < 999) @(negedge clk);
        #1;
        chk("R9 no early pop", 64'(drain_pop), 64'd0);
        @(negedge clk); #1;
        chk("R9 now at head", 64'(now_coarse), 64'd1000);
        chk("R9 pop lane0", 64'(drain_pop), 64'd1);
        chk("R10 drain head", 64'(drain_ev[EV_W-1 -: CT_W]), 64'd1000);
        chk("R6 still held", 64'(ev_ready), 64'd0);
        @(negedge clk); #1;
        chk("R6 released", 64'(ev_ready), 64'd1);
        chk("R6 write lane0", 64'(lane_wr_en), 64'd1);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic t_same_coarse();
        do_reset();
        send("R2 same coarse a", 500, 1, 0);
        send("R2 same coarse b", 500, 3, 1);
        send("R2 same coarse c", 500, 5, 2);
        send("R2 same coarse d", 500, 7, 3);
        #1;
        chk("R7 credit spread", 64'(min_free), 64'(DEP - 1));
        send("R3 lane limit", 500, 7, -1);
        send("R3 pointer moved", 501, 0, 0);
    endtask

    task automatic run_seq(input string tag, input int unsigned off);
        int unsigned ts [7] = '{10, 20, 20, 15, 30, 12, 11};
        int          ln [7] = '{0, 0, 1, 2, 2, 3, -1};
        do_reset();
        for (int k = 0; k < 7; k++) send(tag, ts[k] + off, k, ln[k]);
    endtask

    task automatic t_offset();
        run_seq("R4 base", 0);
        run_seq("R4 offset", 5000);
    endtask

    task automatic t_spread();
        do_reset();
        spread_en = 1'b1;
        for (int k = 0; k < 4 * MARK; k++) send("R5 spread", 1000 + k, 0, k / MARK);
        #1;
        chk("R7 credit after spread", 64'(min_free), 64'(DEP - MARK));
        send("R5 wrap to lane0", 1000 + 4 * MARK, 0, 0);
    endtask

    task automatic t_mark_error();
        do_reset();
        send("R5 setup", 1050, 0, 0);
        send("R5 setup", 1040, 0, 1);
        send("R5 setup", 1030, 0, 2);
        send("R5 setup", 1020, 0, 3);
        for (int k = 1; k <= 5; k++) send("R5 fill lane3", 1020 + k, 0, 3);
        spread_en = 1'b1;
        send("R5 watermark hop error", 1026, 0, -1);
        send("R5 after drop", 1051, 0, 0);
    endtask

    initial begin
        t_reset_state();
        t_single_lane_stall();
        t_same_coarse();
        t_offset();
        t_spread();
        t_mark_error();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule